// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the datapath half of a small processor in which every transfer travels over one shared internal bus. It holds a register file, a program counter, an instruction register, a memory address register, a memory data register, an ALU, an operand latch (Y) in front of the ALU and a result latch (Z) behind it. The block does not decode or sequence anything. An external sequencer presents one control word per clock. The word is a flat set of gating signals: out-enables and in-enables, register-file selects, the ALU function, carry-in, and the memory read, write and wait strobes. The datapath carries out exactly that word in that cycle.

Memory is reached through an address port, a data-out port, a data-in port and request flags for read and write. A memory-function-complete pulse (MFC) answers each request. A control word that asks to wait for that pulse freezes the whole datapath until the pulse arrives, and the block shows the freeze on its stall output. With this rule the sequencer does not need to know the memory latency. A one-step register copy, a three-step memory read, a three-step memory write and a PC increment through the ALU are all built from these words.

Top module: `sbus_datapath`

## Requirements
- R1: In the cycle after synchronous reset is released, these are all zero: PC, IR, Y, Z, MAR (`mem_addr`), MDR (`mem_wdata`), the request flags `mem_rd` and `mem_wr`, `stall`, `bus_conflict` and the bus. Register-file contents are undefined until they are written.
- R2: The bus carries the value of the source whose out-enable is high. The sources are register file at `ctl_rd_sel`, PC, MDR, Z and the IR offset. When no out-enable is high, the bus reads zero.
- R3: When two or more out-enables are high in one cycle, `bus_conflict` is 1 in that cycle. The bus then carries the first enabled source in this order: register file, PC, MDR, Z, IR offset.
- R4: One control word with `ctl_reg_out` and `ctl_reg_in` copies register `ctl_rd_sel` into register `ctl_wr_sel`. The copy is visible on the next cycle.
- R5: The ALU takes Y as operand A and the bus as operand B. The `ctl_alu_op` codes are: 0 = A+B+carry-in, 1 = A-B, 2 = A AND B, 3 = A OR B, 4 = B, and 5 to 7 give zero. Z captures the result only in a cycle with `ctl_z_in` high. Otherwise Z keeps its value.
- R6: A word with PC out, code 0 and carry-in, while Y holds zero, loads PC+1 into Z. A following word with Z out and PC in moves that value into PC.
- R7: `ctl_mar_in` loads MAR from the bus. `ctl_read` sets `mem_rd` from the next cycle, and `mem_rd` stays high until the first cycle with `mem_mfc` high. `ctl_mdr_mem` loads MDR from `mem_rdata`.
- R8: `ctl_mdr_in` loads MDR from the bus, and `mem_wdata` always shows MDR. `ctl_write` sets `mem_wr` from the next cycle, and `mem_wr` stays high until the first cycle with `mem_mfc` high. If `ctl_mdr_mem` and `ctl_mdr_in` are both high, the memory side wins.
- R9: `stall` is high exactly when `ctl_wmfc` is 1 and `mem_mfc` is 0. In a stalled cycle no register updates: register file, PC, IR, Y, Z, MAR, MDR and the setting of the request flags. Only the clearing of a request flag by MFC still takes effect.
- R10: `ctl_ir_in` loads IR from the bus, and `ir_q` shows IR. `ctl_off_out` drives IR bits 7:0, sign-extended to 16 bits, onto the bus.
- R11: `ctl_y_in` loads Y from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reg_out | input | 1 | Register file drives bus |
| ctl_reg_in | input | 1 | Register file captures bus |
| ctl_rd_sel | input | 4 | Register driving the bus |
| ctl_wr_sel | input | 4 | Register capturing the bus |
| ctl_pc_out | input | 1 | PC drives bus |
| ctl_pc_in | input | 1 | PC captures bus |
| ctl_mdr_out | input | 1 | MDR drives bus |
| ctl_mdr_in | input | 1 | MDR captures bus |
| ctl_mdr_mem | input | 1 | MDR captures memory data lines |
| ctl_off_out | input | 1 | Sign-extended IR offset drives bus |
| ctl_ir_in | input | 1 | IR captures bus |
| ctl_mar_in | input | 1 | MAR captures bus |
| ctl_y_in | input | 1 | Y captures bus |
| ctl_z_out | input | 1 | Z drives bus |
| ctl_z_in | input | 1 | Z captures ALU result |
| ctl_alu_op | input | 3 | ALU function code |
| ctl_carry | input | 1 | ALU carry-in for add |
| ctl_read | input | 1 | Start memory read |
| ctl_write | input | 1 | Start memory write |
| ctl_wmfc | input | 1 | Wait for memory completion |
| mem_rdata | input | 16 | Memory read data |
| mem_mfc | input | 1 | Memory function complete |
| mem_addr | output | 16 | MAR contents |
| mem_wdata | output | 16 | MDR contents |
| mem_rd | output | 1 | Read request pending |
| mem_wr | output | 1 | Write request pending |
| ir_q | output | 16 | IR contents |
| bus_mon | output | 16 | Internal bus value |
| stall | output | 1 | Waiting for memory completion |
| bus_conflict | output | 1 | More than one bus source enabled |

## Verification
The bench runs instruction-fetch sequences at memory latencies from zero to four cycles. These show whether the stall lasts exactly until MFC, and whether a zero-latency reply passes through without freezing anything. It runs ALU words with every function code and with Z capture withheld, so a wrong code, a wrong operand order or an unwanted Z update each give a different bus value on the read-back. It drives pairs and triples of out-enables to check the conflict flag and the source priority. It also writes memory and reads the data back through MDR, which separates the write path from the read path. It asserts stray in-enables during a stall to show that nothing moves until the completion pulse.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    ALU_ADD   = 3'd0,
    ALU_SUB   = 3'd1,
    ALU_AND   = 3'd2,
    ALU_OR    = 3'd3,
    ALU_PASSB = 3'd4
  } alu_op_e;

  localparam int SRC_REG = 0;
  localparam int SRC_PC  = 1;
  localparam int SRC_MDR = 2;
  localparam int SRC_Z   = 3;
  localparam int SRC_OFF = 4;
  localparam int NSRC    = 5;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  input  logic         cin,
  output logic [W-1:0] y
);
  import sbus_pkg::*;

  always_comb begin
    case (op)
      ALU_ADD:   y = a + b + W'(cin);
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
  parameter int W    = 16,
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0][W-1:0] src_data,
  input  logic [NSRC-1:0]        src_en,
  output logic [W-1:0]           bus,
  output logic                   conflict
);
  always_comb begin
    bus = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src_en[i]) bus = src_data[i];
    end
    conflict = (src_en & (src_en - NSRC'(1))) != '0;
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W      = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sbus_mem_if.sv
module sbus_mem_if #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] bus,
  input  logic         mar_in,
  input  logic         mdr_in,
  input  logic         mdr_mem,
  input  logic         read,
  input  logic         write,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_mfc,
  output logic [W-1:0] mar,
  output logic [W-1:0] mdr,
  output logic         rd_pend,
  output logic         wr_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mar     <= '0;
      mdr     <= '0;
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      if (mem_mfc) begin
        rd_pend <= 1'b0;
        wr_pend <= 1'b0;
      end
      if (!hold) begin
        if (mar_in) mar <= bus;
        if (mdr_mem)     mdr <= mem_rdata;
        else if (mdr_in) mdr <= bus;
        if (read)  rd_pend <= 1'b1;
        if (write) wr_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int W      = 16,
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_reg_out,
  input  logic              ctl_reg_in,
  input  logic [ADDR_W-1:0] ctl_rd_sel,
  input  logic [ADDR_W-1:0] ctl_wr_sel,
  input  logic              ctl_pc_out,
  input  logic              ctl_pc_in,
  input  logic              ctl_mdr_out,
  input  logic              ctl_mdr_in,
  input  logic              ctl_mdr_mem,
  input  logic              ctl_off_out,
  input  logic              ctl_ir_in,
  input  logic              ctl_mar_in,
  input  logic              ctl_y_in,
  input  logic              ctl_z_out,
  input  logic              ctl_z_in,
  input  logic [2:0]        ctl_alu_op,
  input  logic              ctl_carry,
  input  logic              ctl_read,
  input  logic              ctl_write,
  input  logic              ctl_wmfc,
  input  logic [W-1:0]      mem_rdata,
  input  logic              mem_mfc,
  output logic [W-1:0]      mem_addr,
  output logic [W-1:0]      mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [W-1:0]      ir_q,
  output logic [W-1:0]      bus_mon,
  output logic              stall,
  output logic              bus_conflict
);
  import sbus_pkg::*;

  logic                   hold;
  logic [W-1:0]           bus;
  logic [W-1:0]           rf_rdata;
  logic [W-1:0]           alu_y;
  logic [W-1:0]           pc_q, y_q, z_q, off_ext;
  logic [NSRC-1:0][W-1:0] src_data;
  logic [NSRC-1:0]        src_en;

  assign hold    = ctl_wmfc & ~mem_mfc;
  assign off_ext = {{(W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

  always_comb begin
    src_data[SRC_REG] = rf_rdata;
    src_data[SRC_PC]  = pc_q;
    src_data[SRC_MDR] = mem_wdata;
    src_data[SRC_Z]   = z_q;
    src_data[SRC_OFF] = off_ext;
    src_en[SRC_REG]   = ctl_reg_out;
    src_en[SRC_PC]    = ctl_pc_out;
    src_en[SRC_MDR]   = ctl_mdr_out;
    src_en[SRC_Z]     = ctl_z_out;
    src_en[SRC_OFF]   = ctl_off_out;
  end

  sbus_bus_mux #(.W(W), .NSRC(NSRC)) u_mux (
    .src_data (src_data),
    .src_en   (src_en),
    .bus      (bus),
    .conflict (bus_conflict)
  );

  sbus_regfile #(.W(W), .ADDR_W(ADDR_W)) u_rf (
    .clk   (clk),
    .we    (ctl_reg_in & ~hold),
    .waddr (ctl_wr_sel),
    .wdata (bus),
    .raddr (ctl_rd_sel),
    .rdata (rf_rdata)
  );

  sbus_alu #(.W(W)) u_alu (
    .a   (y_q),
    .b   (bus),
    .op  (ctl_alu_op),
    .cin (ctl_carry),
    .y   (alu_y)
  );

  sbus_mem_if #(.W(W)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .bus       (bus),
    .mar_in    (ctl_mar_in),
    .mdr_in    (ctl_mdr_in),
    .mdr_mem   (ctl_mdr_mem),
    .read      (ctl_read),
    .write     (ctl_write),
    .mem_rdata (mem_rdata),
    .mem_mfc   (mem_mfc),
    .mar       (mem_addr),
    .mdr       (mem_wdata),
    .rd_pend   (mem_rd),
    .wr_pend   (mem_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
      y_q  <= '0;
      z_q  <= '0;
    end else if (!hold) begin
      if (ctl_pc_in) pc_q <= bus;
      if (ctl_ir_in) ir_q <= bus;
      if (ctl_y_in)  y_q  <= bus;
      if (ctl_z_in)  z_q  <= alu_y;
    end
  end

  assign bus_mon = bus;
  assign stall   = hold;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ctl_reg_out,
  input logic         ctl_pc_out,
  input logic         ctl_mdr_out,
  input logic         ctl_z_out,
  input logic         ctl_off_out,
  input logic         ctl_ir_in,
  input logic         ctl_mar_in,
  input logic         ctl_read,
  input logic         mem_mfc,
  input logic [W-1:0] mem_addr,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic [W-1:0] ir_q,
  input logic [W-1:0] bus_mon,
  input logic         stall,
  input logic         bus_conflict
);
  p_idle_bus_r2: assert property (@(posedge clk) disable iff (rst)
    !(ctl_reg_out | ctl_pc_out | ctl_mdr_out | ctl_z_out | ctl_off_out) |-> bus_mon == '0);

  p_two_src_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_reg_out && ctl_pc_out) |-> bus_conflict);

  p_mar_load_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_mar_in && !stall) |=> mem_addr == $past(bus_mon));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_mfc) |=> mem_rd);

  p_rd_done_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_mfc && !(ctl_read && !stall)) |=> !mem_rd);

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_mfc) |=> mem_wr);

  p_stall_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(mem_addr) && $stable(ir_q)));

  p_ir_load_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl_ir_in && !stall) |=> ir_q == $past(bus_mon));
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W)) u_chk (.*);

// File: tb/sbus_datapath_tb.sv
`timescale 1ns/1ps
module sbus_datapath_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic c_reg_out, c_reg_in, c_pc_out, c_pc_in, c_mdr_out, c_mdr_in, c_mdr_mem;
  logic c_off_out, c_ir_in, c_mar_in, c_y_in, c_z_out, c_z_in, c_carry;
  logic c_read, c_write, c_wmfc;
  logic [3:0] c_rd_sel, c_wr_sel;
  logic [2:0] c_op;
  logic [15:0] mem_rdata;
  logic mem_mfc;
  logic [15:0] mem_addr, mem_wdata, ir_q, bus_mon;
  logic mem_rd, mem_wr, stall, bus_conflict;

  sbus_datapath u_dut (
    .clk(clk), .rst(rst),
    .ctl_reg_out(c_reg_out), .ctl_reg_in(c_reg_in),
    .ctl_rd_sel(c_rd_sel), .ctl_wr_sel(c_wr_sel),
    .ctl_pc_out(c_pc_out), .ctl_pc_in(c_pc_in),
    .ctl_mdr_out(c_mdr_out), .ctl_mdr_in(c_mdr_in), .ctl_mdr_mem(c_mdr_mem),
    .ctl_off_out(c_off_out), .ctl_ir_in(c_ir_in), .ctl_mar_in(c_mar_in),
    .ctl_y_in(c_y_in), .ctl_z_out(c_z_out), .ctl_z_in(c_z_in),
    .ctl_alu_op(c_op), .ctl_carry(c_carry),
    .ctl_read(c_read), .ctl_write(c_write), .ctl_wmfc(c_wmfc),
    .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_q(ir_q), .bus_mon(bus_mon), .stall(stall), .bus_conflict(bus_conflict)
  );

  // reference state
  logic [15:0] m_rf [16];
  logic [15:0] bmem [256];
  logic [15:0] m_pc, m_ir, m_y, m_z, m_mar, m_mdr;
  logic m_rd, m_wr;
  int vectors = 0, miscompares = 0;
  int lat = 0, wcnt = 0;
  bit last_stall = 0, done = 0;

  task automatic idle();
    {c_reg_out, c_reg_in, c_pc_out, c_pc_in, c_mdr_out, c_mdr_in, c_mdr_mem} = '0;
    {c_off_out, c_ir_in, c_mar_in, c_y_in, c_z_out, c_z_in, c_carry} = '0;
    {c_read, c_write, c_wmfc} = '0;
    c_rd_sel = '0; c_wr_sel = '0; c_op = '0;
  endtask

  function automatic logic [15:0] ref_alu(logic [15:0] a, logic [15:0] b, int op, logic ci);
    case (op)
      0: return a + b + {15'd0, ci};
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return b;
      default: return 16'h0;
    endcase
  endfunction

  task automatic exp_bus(output logic [15:0] b, output logic cf);
    int n;
    n = int'(c_reg_out) + int'(c_pc_out) + int'(c_mdr_out) + int'(c_z_out) + int'(c_off_out);
    cf = (n > 1);
    if (c_reg_out)      b = m_rf[c_rd_sel];
    else if (c_pc_out)  b = m_pc;
    else if (c_mdr_out) b = m_mdr;
    else if (c_z_out)   b = m_z;
    else if (c_off_out) b = {{8{m_ir[7]}}, m_ir[7:0]};
    else                b = 16'h0;
  endtask

  task automatic mem_drive();
    mem_mfc = 1'b0;
    mem_rdata = 16'h0;
    if (m_rd || m_wr) begin
      if (wcnt >= lat) begin
        mem_mfc = 1'b1;
        if (m_rd) mem_rdata = bmem[m_mar[7:0]];
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  endtask

  task automatic compare();
    logic [15:0] eb; logic ec, es; int nf;
    nf = 0;
    exp_bus(eb, ec);
    es = c_wmfc && !mem_mfc;
    vectors++;
    if (bus_mon !== eb) begin nf++; $display("FAIL R2/R3 bus actual %h expected %h", bus_mon, eb); end
    if (bus_conflict !== ec) begin nf++; $display("FAIL R3 conflict actual %b expected %b", bus_conflict, ec); end
    if (stall !== es) begin nf++; $display("FAIL R9 stall actual %b expected %b", stall, es); end
    if (mem_addr !== m_mar) begin nf++; $display("FAIL R7 mem_addr actual %h expected %h", mem_addr, m_mar); end
    if (mem_wdata !== m_mdr) begin nf++; $display("FAIL R8 mem_wdata actual %h expected %h", mem_wdata, m_mdr); end
    if (mem_rd !== m_rd) begin nf++; $display("FAIL R7 mem_rd actual %b expected %b", mem_rd, m_rd); end
    if (mem_wr !== m_wr) begin nf++; $display("FAIL R8 mem_wr actual %b expected %b", mem_wr, m_wr); end
    if (ir_q !== m_ir) begin nf++; $display("FAIL R10 ir actual %h expected %h", ir_q, m_ir); end
    if (nf > 0) miscompares++;
    last_stall = es;
  endtask

  task automatic model_update();
    logic [15:0] b, r; logic cf;
    exp_bus(b, cf);
    r = ref_alu(m_y, b, int'(c_op), c_carry);
    if (mem_mfc) begin
      if (m_wr) bmem[m_mar[7:0]] = m_mdr;
      m_rd = 0; m_wr = 0;
    end
    if (!(c_wmfc && !mem_mfc)) begin
      if (c_reg_in) m_rf[c_wr_sel] = b;
      if (c_pc_in) m_pc = b;
      if (c_ir_in) m_ir = b;
      if (c_y_in) m_y = b;
      if (c_z_in) m_z = r;
      if (c_mar_in) m_mar = b;
      if (c_mdr_mem) m_mdr = mem_rdata;
      else if (c_mdr_in) m_mdr = b;
      if (c_read) m_rd = 1;
      if (c_write) m_wr = 1;
    end
  endtask

  // one control word, held through any stall cycles
  task automatic tick();
    do begin
      mem_drive();
      #1;
      compare();
      model_update();
      @(negedge clk);
    end while (last_stall);
    idle();
  endtask

  // R7 read into a register: fetch-style with PC increment (R6)
  task automatic fetch_to(int dst, bit to_ir);
    c_pc_out = 1; c_mar_in = 1; c_read = 1; c_op = 3'd0; c_carry = 1; c_z_in = 1; tick();
    c_z_out = 1; c_pc_in = 1; c_mdr_mem = 1; c_wmfc = 1; tick();
    c_mdr_out = 1;
    if (to_ir) c_ir_in = 1; else begin c_reg_in = 1; c_wr_sel = 4'(dst); end
    tick();
  endtask

  initial begin
    idle();
    mem_mfc = 0; mem_rdata = 0;
    for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 16'h1357 + 16'h00a5);
    for (int i = 0; i < 16; i++) m_rf[i] = 16'h0;
    {m_pc, m_ir, m_y, m_z, m_mar, m_mdr} = '0;
    m_rd = 0; m_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    vectors++;
    if ({mem_addr, mem_wdata, ir_q, bus_mon} !== 64'h0 || {mem_rd, mem_wr, stall, bus_conflict} !== 4'b0) begin
      miscompares++;
      $display("FAIL R1 reset state actual %h %h %h %h %b%b%b%b expected all zero",
               mem_addr, mem_wdata, ir_q, bus_mon, mem_rd, mem_wr, stall, bus_conflict);
    end
    @(negedge clk);

    // R11 / R2: Y from an idle bus is zero
    c_y_in = 1; tick();
    // R6/R7/R9: fetches at latencies 0..4
    for (int k = 1; k <= 6; k++) begin lat = k % 5; fetch_to(k, 0); end
    // R10: instruction load and sign-extended offset
    lat = 2; fetch_to(0, 1);
    c_off_out = 1; c_reg_in = 1; c_wr_sel = 4'd14; tick();
    c_reg_out = 1; c_rd_sel = 4'd14; tick();
    // R4: copy R1 to R7 then read back
    c_reg_out = 1; c_rd_sel = 4'd1; c_reg_in = 1; c_wr_sel = 4'd7; tick();
    c_reg_out = 1; c_rd_sel = 4'd7; tick();
    // R5: every ALU code with Y=R1, B=R2
    c_reg_out = 1; c_rd_sel = 4'd1; c_y_in = 1; tick();
    for (int op = 0; op < 6; op++) begin
      c_reg_out = 1; c_rd_sel = 4'd2; c_op = 3'(op); c_carry = (op == 1); c_z_in = 1; tick();
      c_z_out = 1; c_reg_in = 1; c_wr_sel = 4'(8 + op); tick();
      c_reg_out = 1; c_rd_sel = 4'(8 + op); tick();
    end
    // R5: Z untouched without z_in
    c_reg_out = 1; c_rd_sel = 4'd3; c_op = 3'd2; tick();
    c_z_out = 1; tick();
    // R3: conflicts and priority
    c_reg_out = 1; c_rd_sel = 4'd4; c_pc_out = 1; c_reg_in = 1; c_wr_sel = 4'd15; tick();
    c_pc_out = 1; c_mdr_out = 1; c_z_out = 1; tick();
    c_z_out = 1; c_off_out = 1; tick();
    c_reg_out = 1; c_rd_sel = 4'd15; tick();
    // R8: write R4 to address R3, latency 3, then read back into R9
    lat = 3;
    c_reg_out = 1; c_rd_sel = 4'd3; c_mar_in = 1; tick();
    c_reg_out = 1; c_rd_sel = 4'd4; c_mdr_in = 1; c_write = 1; tick();
    c_wmfc = 1; tick();
    c_pc_out = 1; c_mdr_in = 1; tick();
    c_read = 1; tick();
    // R9: stray enables during the stall must not act
    c_mdr_mem = 1; c_wmfc = 1; c_y_in = 1; c_reg_out = 1; c_rd_sel = 4'd5; c_z_in = 1; tick();
    c_mdr_out = 1; c_reg_in = 1; c_wr_sel = 4'd9; tick();
    c_reg_out = 1; c_rd_sel = 4'd9; tick();
    c_z_out = 1; tick();
    // R8: memory side wins over bus when both MDR loads set
    lat = 1;
    c_read = 1; tick();
    c_mdr_mem = 1; c_mdr_in = 1; c_pc_out = 1; c_wmfc = 1; tick();
    c_mdr_out = 1; tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule